// File: doc/BRIEF.md
# Token Serial Number Table

This block keeps the current token serial number for each memory line that needs one. Every cache and the memory controller holds one copy. A serial number is a small wrapping counter. The recreation process advances it each time it rebuilds a line's tokens, and the table uses it to reject stale coherence responses that were still in flight when the tokens were rebuilt. Only lines whose serial number is non-zero take a slot. A line that is not present reads as zero, so a small fully associative store covers any address space.

The block has three ports:

- **Lookup port.** It takes a line address and the serial number carried by an incoming response. One cycle later it returns the line's current number and a discard flag that is set when the two differ.
- **Update port.** The recreation process uses it to set a line's number or to advance it by one. Writing zero releases the slot.
- **Clear port.** It forces a line back to zero and releases its slot.

When an update needs a new slot and all slots are taken, the update is held. The table then raises a recreation request naming the line that was modified longest ago. Once that line has been cleared, the held update goes through.

Top module: `tsn_table`

## Requirements
- R1: A lookup of a line that holds no slot returns serial number 0.
- R2: When `lk_valid` is high at a clock edge, `lk_done` and `lk_cur_sn` are valid right after that edge. `lk_cur_sn` reflects the table as it stood before any write made at the same edge.
- R3: `lk_discard` is high exactly when the returned current number differs from the `lk_sn_in` presented with the lookup.
- R4: An accepted update with `upd_op` = 0 sets the line's number to `upd_sn`. A non-zero value for an absent line takes a free slot.
- R5: An accepted update with `upd_op` = 1 advances the line's number by one, modulo 4 (2-bit numbers), and ignores `upd_sn`. An absent line becomes 1, and 3 wraps to 0.
- R6: Any write that leaves a line at zero releases its slot. This covers a set to 0, an advance from 3, and a clear. Afterwards the line reads 0 and the slot can be taken by another line.
- R7: The table holds 16 distinct non-zero lines at the same time, and no line ever occupies two slots.
- R8: When all 16 slots are full, an update that needs a new slot sees `upd_ready` = 0. `rec_req_valid` = 1 and `rec_req_addr` names the line modified longest ago; that address stays stable while the request is held. Updates to lines already present are still accepted.
- R9: Only writes change the modification order. Lookups leave it untouched, and rewriting a line makes it the most recently modified.
- R10: Once the victim is cleared, the held update is accepted on the next edge at which it is presented, and the new line reads back its value.
- R11: A clear has priority over an update. While `clr_valid` is high, `upd_ready` is 0.
- R12: After reset every line reads 0, `upd_ready` is 1 for any update, and `rec_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 24 | Line address to look up |
| lk_sn_in | input | 2 | Serial number carried by the incoming response |
| lk_done | output | 1 | Lookup result valid |
| lk_cur_sn | output | 2 | Current serial number of the looked-up line |
| lk_discard | output | 1 | Response number differs from the current one |
| upd_valid | input | 1 | Update request |
| upd_op | input | 1 | 0: set to `upd_sn`, 1: advance by one |
| upd_addr | input | 24 | Line address to update |
| upd_sn | input | 2 | Value for a set |
| upd_ready | output | 1 | Update accepted at this edge when high |
| clr_valid | input | 1 | Clear request (line to zero) |
| clr_addr | input | 24 | Line address to clear |
| rec_req_valid | output | 1 | Table full; recreation of the victim requested |
| rec_req_addr | output | 24 | Least-recently-modified line to reset |

## Verification
Lookup results are registered. They appear one edge after the request, so the bench drives a lookup at a falling edge and samples just after the following rising edge. `upd_ready` and the recreation request are combinational on the current inputs and table contents. The bench therefore samples them shortly after driving, within the same low phase and before the edge that would accept the update. A write takes effect at the edge that accepts it, and its value is read back through a later lookup. To show that a lookup issued alongside a write sees the old value, both are driven in the same cycle.

// File: rtl/tsn_pkg.sv
package tsn_pkg;

    // Update operation selected by upd_op
    typedef enum logic {
        TSN_OP_SET = 1'b0,
        TSN_OP_INC = 1'b1
    } tsn_op_e;

endpackage

// File: rtl/tsn_cam.sv
// Parallel tag compare across all slots; returns hit vector and encoded index.
module tsn_cam #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic [IDX_W-1:0]               hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tag[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tsn_free_pick.sv
// Finds the lowest-numbered empty slot.
module tsn_free_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld,
    output logic               full,
    output logic [IDX_W-1:0]   free_idx
);

    assign full = &vld;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tsn_age.sv
// Modification-age ranks: a permutation of 0..ENTRIES-1, rank 0 = newest write.
module tsn_age #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);

    localparam logic [IDX_W-1:0] RANK_MAX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] rank_d, rank_q;

    always_comb begin
        rank_d = rank_q;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    rank_d[i] = '0;
                end else if (rank_q[i] < rank_q[touch_idx]) begin
                    rank_d[i] = rank_q[i] + IDX_W'(1);
                end
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank_q[i] == RANK_MAX) oldest_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
        end else begin
            rank_q <= rank_d;
        end
    end

endmodule

// File: rtl/tsn_table.sv
module tsn_table
    import tsn_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 24,
    parameter int SN_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SN_W-1:0]   lk_sn_in,
    output logic              lk_done,
    output logic [SN_W-1:0]   lk_cur_sn,
    output logic              lk_discard,
    input  logic              upd_valid,
    input  logic              upd_op,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [SN_W-1:0]   upd_sn,
    output logic              upd_ready,
    input  logic              clr_valid,
    input  logic [ADDR_W-1:0] clr_addr,
    output logic              rec_req_valid,
    output logic [ADDR_W-1:0] rec_req_addr
);

    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][SN_W-1:0]   sn;
        logic                           lk_done;
        logic [SN_W-1:0]                lk_sn;
        logic                           lk_disc;
    } state_t;

    state_t st_d, st_q;

    // Tag match for each access port
    logic [ENTRIES-1:0] lk_hit_vec, upd_hit_vec, clr_hit_vec;
    logic [IDX_W-1:0]   lk_idx, upd_idx, clr_idx;
    logic               lk_hit, upd_hit, clr_hit;

    tsn_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam_lk (
        .vld(st_q.vld), .tag(st_q.tag), .key(lk_addr),
        .hit_vec(lk_hit_vec), .hit_idx(lk_idx)
    );
    tsn_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam_upd (
        .vld(st_q.vld), .tag(st_q.tag), .key(upd_addr),
        .hit_vec(upd_hit_vec), .hit_idx(upd_idx)
    );
    tsn_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam_clr (
        .vld(st_q.vld), .tag(st_q.tag), .key(clr_addr),
        .hit_vec(clr_hit_vec), .hit_idx(clr_idx)
    );

    assign lk_hit  = |lk_hit_vec;
    assign upd_hit = |upd_hit_vec;
    assign clr_hit = |clr_hit_vec;

    // Slot allocation and victim choice
    logic             tbl_full;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] oldest_idx;
    logic             age_touch;
    logic [IDX_W-1:0] age_idx;

    tsn_free_pick #(.ENTRIES(ENTRIES)) u_free (
        .vld(st_q.vld), .full(tbl_full), .free_idx(free_idx)
    );

    tsn_age #(.ENTRIES(ENTRIES)) u_age (
        .clk(clk), .rst_n(rst_n),
        .touch(age_touch), .touch_idx(age_idx),
        .oldest_idx(oldest_idx)
    );

    // Update-side decode
    tsn_op_e          op;
    logic [SN_W-1:0]  lk_cur;
    logic [SN_W-1:0]  upd_cur;
    logic [SN_W-1:0]  upd_new;
    logic             need_alloc;
    logic             upd_fire;

    always_comb begin
        op         = tsn_op_e'(upd_op);
        lk_cur     = lk_hit ? st_q.sn[lk_idx] : '0;
        upd_cur    = upd_hit ? st_q.sn[upd_idx] : '0;
        upd_new    = (op == TSN_OP_INC) ? upd_cur + SN_W'(1) : upd_sn;
        need_alloc = !upd_hit && (upd_new != '0);
        upd_ready  = !clr_valid && !(need_alloc && tbl_full);
        upd_fire   = upd_valid && upd_ready;
    end

    // Next-state
    always_comb begin
        st_d      = st_q;
        age_touch = 1'b0;
        age_idx   = '0;

        // lookup result against pre-write contents
        st_d.lk_done = lk_valid;
        st_d.lk_disc = lk_valid && (lk_cur != lk_sn_in);
        if (lk_valid) st_d.lk_sn = lk_cur;

        // clear port has priority and blocks the update port
        if (clr_valid && clr_hit) begin
            st_d.vld[clr_idx] = 1'b0;
            st_d.sn[clr_idx]  = '0;
        end

        if (upd_fire) begin
            if (upd_hit) begin
                if (upd_new == '0) begin
                    st_d.vld[upd_idx] = 1'b0;
                    st_d.sn[upd_idx]  = '0;
                end else begin
                    st_d.sn[upd_idx] = upd_new;
                    age_touch        = 1'b1;
                    age_idx          = upd_idx;
                end
            end else if (upd_new != '0) begin
                st_d.vld[free_idx] = 1'b1;
                st_d.tag[free_idx] = upd_addr;
                st_d.sn[free_idx]  = upd_new;
                age_touch          = 1'b1;
                age_idx            = free_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_done       = st_q.lk_done;
    assign lk_cur_sn     = st_q.lk_sn;
    assign lk_discard    = st_q.lk_disc;
    assign rec_req_valid = upd_valid && need_alloc && tbl_full;
    assign rec_req_addr  = st_q.tag[oldest_idx];

endmodule

// File: rtl/tsn_table_chk.sv
module tsn_table_chk #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 24,
    parameter int SN_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [SN_W-1:0]   lk_sn_in,
    input logic              lk_done,
    input logic [SN_W-1:0]   lk_cur_sn,
    input logic              lk_discard,
    input logic              upd_valid,
    input logic              upd_ready,
    input logic              clr_valid,
    input logic              rec_req_valid,
    input logic [ADDR_W-1:0] rec_req_addr,
    input logic [ENTRIES-1:0] lk_hit_vec
);

    assert_lookup_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    assert_lookup_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done);

    assert_discard_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> (lk_discard == (lk_cur_sn != $past(lk_sn_in))));

    assert_unique_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    assert_stall_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !clr_valid && !upd_ready) |-> rec_req_valid);

    assert_victim_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_req_valid && $past(rec_req_valid)) |-> $stable(rec_req_addr));

    assert_clear_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> !upd_ready);

endmodule

bind tsn_table tsn_table_chk #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SN_W(SN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_sn_in(lk_sn_in),
    .lk_done(lk_done), .lk_cur_sn(lk_cur_sn), .lk_discard(lk_discard),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .clr_valid(clr_valid),
    .rec_req_valid(rec_req_valid), .rec_req_addr(rec_req_addr),
    .lk_hit_vec(lk_hit_vec)
);

// File: tb/tsn_table_tb.sv
module tsn_table_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int SN_W       = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [SN_W-1:0]   lk_sn_in = '0;
    logic              lk_done;
    logic [SN_W-1:0]   lk_cur_sn;
    logic              lk_discard;
    logic              upd_valid = 1'b0;
    logic              upd_op = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [SN_W-1:0]   upd_sn = '0;
    logic              upd_ready;
    logic              clr_valid = 1'b0;
    logic [ADDR_W-1:0] clr_addr = '0;
    logic              rec_req_valid;
    logic [ADDR_W-1:0] rec_req_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsn_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_sn_in(lk_sn_in),
        .lk_done(lk_done), .lk_cur_sn(lk_cur_sn), .lk_discard(lk_discard),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_addr(upd_addr),
        .upd_sn(upd_sn), .upd_ready(upd_ready),
        .clr_valid(clr_valid), .clr_addr(clr_addr),
        .rec_req_valid(rec_req_valid), .rec_req_addr(rec_req_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Lookup: drive at negedge, sample just after the following posedge
    task automatic lookup(input logic [ADDR_W-1:0] a, input logic [SN_W-1:0] s,
                          input logic [SN_W-1:0] exp_sn, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_sn_in = s;
        @(posedge clk); #1;
        lk_valid = 1'b0;
        check(lk_done == 1'b1, req, "lookup done", lk_done, 1);
        check(lk_cur_sn == exp_sn, req, "current serial", lk_cur_sn, exp_sn);
        check(lk_discard == (exp_sn != s), req, "discard flag", lk_discard, exp_sn != s);
    endtask

    task automatic update(input logic op, input logic [ADDR_W-1:0] a,
                          input logic [SN_W-1:0] s, input string req);
        @(negedge clk);
        upd_valid = 1'b1; upd_op = op; upd_addr = a; upd_sn = s;
        #1;
        check(upd_ready == 1'b1, req, "update ready", upd_ready, 1);
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic clear(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        clr_valid = 1'b1; clr_addr = a;
        @(posedge clk); #1;
        clr_valid = 1'b0;
    endtask

    task automatic t_reset();
        apply_reset();
        @(negedge clk);
        upd_op = 1'b0; upd_addr = 24'h123; upd_sn = 2'd3;
        #1;
        check(upd_ready == 1'b1, "R12", "ready after reset", upd_ready, 1);
        check(rec_req_valid == 1'b0, "R12", "no recreation after reset", rec_req_valid, 0);
        check(lk_done == 1'b0, "R12", "no result after reset", lk_done, 0);
        lookup(24'h000005, 2'd0, 2'd0, "R12");
        lookup(24'hABCDEF, 2'd1, 2'd0, "R1");
    endtask

    task automatic t_set_lookup();
        update(1'b0, 24'h000A00, 2'd2, "R4");
        lookup(24'h000A00, 2'd2, 2'd2, "R4");
        lookup(24'h000A00, 2'd1, 2'd2, "R3");
        lookup(24'h000A00, 2'd0, 2'd2, "R3");
        lookup(24'h000A01, 2'd0, 2'd0, "R1");
        update(1'b0, 24'h000A00, 2'd3, "R4");
        lookup(24'h000A00, 2'd3, 2'd3, "R4");
    endtask

    task automatic t_increment();
        update(1'b1, 24'h000B00, 2'd2, "R5");
        lookup(24'h000B00, 2'd1, 2'd1, "R5");
        update(1'b1, 24'h000B00, 2'd0, "R5");
        update(1'b1, 24'h000B00, 2'd0, "R5");
        lookup(24'h000B00, 2'd3, 2'd3, "R5");
        update(1'b1, 24'h000B00, 2'd0, "R5");
        lookup(24'h000B00, 2'd3, 2'd0, "R6");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid = 1'b1; upd_op = 1'b0; upd_addr = 24'h000C00; upd_sn = 2'd3;
        lk_valid = 1'b1; lk_addr = 24'h000C00; lk_sn_in = 2'd3;
        @(posedge clk); #1;
        upd_valid = 1'b0; lk_valid = 1'b0;
        check(lk_cur_sn == 2'd0, "R2", "lookup sees pre-write value", lk_cur_sn, 0);
        check(lk_discard == 1'b1, "R2", "pre-write mismatch", lk_discard, 1);
        lookup(24'h000C00, 2'd3, 2'd3, "R2");
    endtask

    task automatic t_full_stall();
        apply_reset();
        for (int i = 0; i < 16; i++) update(1'b0, 24'h000100 + ADDR_W'(i), 2'd1, "R7");
        for (int i = 0; i < 16; i++) lookup(24'h000100 + ADDR_W'(i), 2'd1, 2'd1, "R7");
        // existing line still writable when full; makes 0x101 the oldest
        update(1'b0, 24'h000100, 2'd2, "R8");
        lookup(24'h000101, 2'd1, 2'd1, "R9");
        @(negedge clk);
        upd_valid = 1'b1; upd_op = 1'b0; upd_addr = 24'h000200; upd_sn = 2'd1;
        #1;
        check(upd_ready == 1'b0, "R8", "stall when full", upd_ready, 0);
        check(rec_req_valid == 1'b1, "R8", "recreation requested", rec_req_valid, 1);
        check(rec_req_addr == 24'h000101, "R9", "victim is least recently modified",
              rec_req_addr, 24'h000101);
        @(negedge clk); #1;
        check(upd_ready == 1'b0, "R8", "still stalled", upd_ready, 0);
        check(rec_req_addr == 24'h000101, "R8", "victim held", rec_req_addr, 24'h000101);
        @(negedge clk);
        clr_valid = 1'b1; clr_addr = 24'h000101;
        #1;
        check(upd_ready == 1'b0, "R11", "clear blocks update", upd_ready, 0);
        @(negedge clk);
        clr_valid = 1'b0;
        #1;
        check(upd_ready == 1'b1, "R10", "stall released", upd_ready, 1);
        check(rec_req_valid == 1'b0, "R10", "request dropped", rec_req_valid, 0);
        @(posedge clk); #1;
        upd_valid = 1'b0;
        lookup(24'h000200, 2'd1, 2'd1, "R10");
        lookup(24'h000101, 2'd1, 2'd0, "R6");
        // set to zero frees a slot in a full table
        update(1'b0, 24'h000102, 2'd0, "R6");
        lookup(24'h000102, 2'd0, 2'd0, "R6");
        update(1'b0, 24'h000300, 2'd3, "R6");
        lookup(24'h000300, 2'd3, 2'd3, "R6");
        // full again: oldest now 0x103
        @(negedge clk);
        upd_valid = 1'b1; upd_op = 1'b1; upd_addr = 24'h000400; upd_sn = 2'd0;
        #1;
        check(upd_ready == 1'b0, "R8", "stall on increment alloc", upd_ready, 0);
        check(rec_req_addr == 24'h000103, "R9", "victim after rewrites",
              rec_req_addr, 24'h000103);
        @(negedge clk);
        upd_valid = 1'b0;
        lookup(24'h000400, 2'd0, 2'd0, "R8");
    endtask

    initial begin
        t_reset();
        t_set_lookup();
        t_increment();
        t_same_cycle();
        t_full_stall();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule